// File: doc/BRIEF.md
# Pipelined 32x32 Integer Multiplier

This block is the hardware multiply unit of a 32-bit integer pipeline. Each cycle it can take a pair of 32-bit operands together with two control bits: one selects two's-complement or unsigned interpretation, and the other asks for the integer condition codes to be updated. A single datapath serves all four operation kinds. It extends both operands by one bit, zero-extending for unsigned and sign-extending for signed. It then multiplies them as signed numbers in two pipelined stages and produces the full 64-bit product.

The upper half of the product is presented on a separate high-word output. The lower half is the instruction result. For the code-setting variants, the block also presents negative, zero, overflow and carry flags derived from the lower half, with a strobe that tells the integer unit to latch them. A new operation may be issued every cycle. Each result appears exactly two cycles after issue, with a valid strobe that tracks the input strobe. Writeback, hazard tracking and accumulate operations belong to the surrounding pipeline.

Top module: `mul32_pipe`

## Requirements
- R1: With `is_signed` low, `{res_hi, res_lo}` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R2: With `is_signed` high, `{res_hi, res_lo}` equals the two's-complement 64-bit product of `op_a` and `op_b`, including the most negative operand values.
- R3: `res_hi` carries product bits 63:32 and `res_lo` carries product bits 31:0.
- R4: An operation sampled with `in_valid` high on a rising edge yields `out_valid` high on the second following rising edge, with its result. `out_valid` is low in every cycle that no issue two edges earlier accounts for. Back-to-back issues give back-to-back results in issue order.
- R5: `cc_update` is high only with `out_valid` and only for an operation issued with `set_cc` high. For an operation without `set_cc`, `cc_update` stays low while its result is presented.
- R6: When `cc_update` is high, `cc_nzvc` bit 3 (N) equals `res_lo[31]`, bit 2 (Z) is 1 exactly when `res_lo` is zero, and bits 1 (V) and 0 (C) are 0.
- R7: Asserting `rst_n` low clears every pipeline valid bit. No operation that was in flight before reset produces `out_valid` afterwards.
- R8: Operations of different mode (signed/unsigned, with or without `set_cc`) issued on consecutive cycles are each computed in their own mode, with no leakage between neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Issue strobe for a new operation |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| set_cc | input | 1 | 1: update condition codes from the result |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| res_lo | output | 32 | Low product word, the instruction result |
| res_hi | output | 32 | High product word |
| cc_update | output | 1 | Condition codes are to be latched this cycle |
| cc_nzvc | output | 4 | Flags N, Z, V, C in bits 3..0 |

## Verification
The hardest condition to reach from the ports is a reset that lands while operations are still in the pipeline. The bench issues operations on consecutive cycles, pulls reset low part-way through, drops the queued expectations, and watches that no stray result strobe appears after release. A second stressed case is a dense stream in which mode and code-setting flags change every cycle and issue bubbles are mixed in. This stream shows both per-operation mode tracking and exact two-cycle timing. It runs beside directed extreme operands such as the most negative value squared and all-ones times all-ones.

// File: rtl/mul32_pipe_pkg.sv
package mul32_pipe_pkg;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } icc_flags_t;

  localparam int unsigned FLAG_BITS = $bits(icc_flags_t);

endpackage

// File: rtl/mul_pp_stage.sv
// First pipeline stage: operand extension and two signed partial products.
module mul_pp_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SPLIT = 16,
  localparam int unsigned AW   = WIDTH + 1,
  localparam int unsigned LOW  = SPLIT + 1,
  localparam int unsigned HIW  = WIDTH - SPLIT + 1,
  localparam int unsigned PLW  = AW + LOW,
  localparam int unsigned PHW  = AW + HIW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [WIDTH-1:0]      op_a,
  input  logic [WIDTH-1:0]      op_b,
  input  logic                  is_signed,
  input  logic                  set_cc,
  output logic                  s1_valid,
  output logic                  s1_set_cc,
  output logic signed [PLW-1:0] s1_pp_lo,
  output logic signed [PHW-1:0] s1_pp_hi
);

  logic signed [AW-1:0]  a_ext;
  logic signed [LOW-1:0] b_lo_part;
  logic signed [HIW-1:0] b_hi_part;
  logic signed [PLW-1:0] pp_lo_d;
  logic signed [PHW-1:0] pp_hi_d;
  logic                  valid_d;
  logic                  load_en;

  // Extension bit decides the mode: sign copy or zero.
  always_comb begin
    a_ext     = {is_signed & op_a[WIDTH-1], op_a};
    b_lo_part = {1'b0, op_b[SPLIT-1:0]};
    b_hi_part = {is_signed & op_b[WIDTH-1], op_b[WIDTH-1:SPLIT]};
    pp_lo_d   = PLW'(a_ext) * PLW'(b_lo_part);
    pp_hi_d   = PHW'(a_ext) * PHW'(b_hi_part);
    valid_d   = in_valid;
    load_en   = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      s1_set_cc <= set_cc;
      s1_pp_lo  <= pp_lo_d;
      s1_pp_hi  <= pp_hi_d;
    end
  end

endmodule

// File: rtl/mul_sum_stage.sv
// Second pipeline stage: partial product sum, output split and flags.
module mul_sum_stage
  import mul32_pipe_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SPLIT = 16,
  localparam int unsigned AW   = WIDTH + 1,
  localparam int unsigned PLW  = AW + SPLIT + 1,
  localparam int unsigned PHW  = AW + WIDTH - SPLIT + 1,
  localparam int unsigned PW   = 2 * WIDTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s1_valid,
  input  logic                  s1_set_cc,
  input  logic signed [PLW-1:0] s1_pp_lo,
  input  logic signed [PHW-1:0] s1_pp_hi,
  output logic                  s2_valid,
  output logic [WIDTH-1:0]      s2_lo,
  output logic [WIDTH-1:0]      s2_hi,
  output logic                  s2_cc_upd,
  output icc_flags_t            s2_flags
);

  logic [PW-1:0] product;
  icc_flags_t    flags_d;
  logic          valid_d;
  logic          upd_d;

  always_comb begin
    product       = PW'(s1_pp_lo) + (PW'(s1_pp_hi) << SPLIT);
    flags_d.neg   = product[WIDTH-1];
    flags_d.zero  = ~|product[WIDTH-1:0];
    flags_d.ovf   = 1'b0;
    flags_d.carry = 1'b0;
    valid_d       = s1_valid;
    upd_d         = s1_valid & s1_set_cc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_cc_upd <= 1'b0;
    end else begin
      s2_valid  <= valid_d;
      s2_cc_upd <= upd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_lo    <= product[WIDTH-1:0];
      s2_hi    <= product[PW-1:WIDTH];
      s2_flags <= flags_d;
    end
  end

  // R6: a zero low word and the Z flag agree whenever flags are published
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_cc_upd |-> (s2_flags.zero == (s2_lo == '0)));

  // R6: negative flag mirrors the low word's top bit
  assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_cc_upd |-> (s2_flags.neg == s2_lo[WIDTH-1]));

endmodule

// File: rtl/mul32_pipe.sv
module mul32_pipe
  import mul32_pipe_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SPLIT = WIDTH / 2,
  localparam int unsigned AW   = WIDTH + 1,
  localparam int unsigned PLW  = AW + SPLIT + 1,
  localparam int unsigned PHW  = AW + WIDTH - SPLIT + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  input  logic                 is_signed,
  input  logic                 set_cc,
  output logic                 out_valid,
  output logic [WIDTH-1:0]     res_lo,
  output logic [WIDTH-1:0]     res_hi,
  output logic                 cc_update,
  output logic [FLAG_BITS-1:0] cc_nzvc
);

  logic                  s1_valid;
  logic                  s1_set_cc;
  logic signed [PLW-1:0] s1_pp_lo;
  logic signed [PHW-1:0] s1_pp_hi;
  icc_flags_t            s2_flags;

  mul_pp_stage #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_pp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .set_cc    (set_cc),
    .s1_valid  (s1_valid),
    .s1_set_cc (s1_set_cc),
    .s1_pp_lo  (s1_pp_lo),
    .s1_pp_hi  (s1_pp_hi)
  );

  mul_sum_stage #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_set_cc (s1_set_cc),
    .s1_pp_lo  (s1_pp_lo),
    .s1_pp_hi  (s1_pp_hi),
    .s2_valid  (out_valid),
    .s2_lo     (res_lo),
    .s2_hi     (res_hi),
    .s2_cc_upd (cc_update),
    .s2_flags  (s2_flags)
  );

  assign cc_nzvc = s2_flags;

  // R4: an issue reaches the middle stage one edge later
  assert_issue_to_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R4: the output strobe follows the middle stage by one edge, both ways
  assert_mid_to_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  assert_no_spurious_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R5: flag strobe never without a result
  assert_cc_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_update |-> out_valid);

  // R6: overflow and carry stay clear when flags are published
  assert_vc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cc_update |-> (cc_nzvc[1:0] == 2'b00));

endmodule

// File: tb/mul32_pipe_tb.sv
module mul32_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        upd;
    logic [3:0]  cc;
    logic        sgn;
    int          due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        is_signed, set_cc;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic        cc_update;
  logic [3:0]  cc_nzvc;

  exp_t exp_q[$];
  int   cycle = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   ended = 0;

  mul32_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .set_cc(set_cc), .out_valid(out_valid),
    .res_lo(res_lo), .res_hi(res_hi), .cc_update(cc_update), .cc_nzvc(cc_nzvc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cycle);
    end
  endtask

  // Driver: issues one operation at the current negedge and queues its expectation.
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sg, input logic cc);
    exp_t e;
    logic [63:0] p;
    if (sg) p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    else    p = {32'b0, a} * {32'b0, b};
    e.lo  = p[31:0];
    e.hi  = p[63:32];
    e.upd = cc;
    e.cc  = {p[31], p[31:0] == 32'b0, 2'b00};
    e.sgn = sg;
    e.due = cycle + 2;
    exp_q.push_back(e);
    in_valid = 1'b1; op_a = a; op_b = b; is_signed = sg; set_cc = cc;
    @(negedge clk);
    in_valid = 1'b0;
    op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; is_signed = ~sg; set_cc = ~cc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares every presented result against the queue head.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !ended) begin
      if (out_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected out_valid", 64'(out_valid), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.sgn ? "R2 signed product" : "R1 unsigned product",
                {res_hi, res_lo}, {e.hi, e.lo});
          check("R3 high word", 64'(res_hi), 64'(e.hi));
          check("R4 latency cycle", 64'(cycle), 64'(e.due));
          check("R5 cc_update", 64'(cc_update), 64'(e.upd));
          if (e.upd) check("R6 nzvc flags", 64'(cc_nzvc), 64'(e.cc));
        end
      end else begin
        if (exp_q.size() != 0 && exp_q[0].due <= cycle)
          check("R4 missing out_valid", 64'(out_valid), 64'd1);
        if (cc_update !== 1'b0) check("R5 cc_update without result", 64'(cc_update), 64'd0);
      end
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; is_signed = 0; set_cc = 0;
    idle(3);
    // R7: reset state
    check("R7 reset out_valid", 64'(out_valid), 64'd0);
    check("R7 reset cc_update", 64'(cc_update), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 unsigned corners
    issue(32'h0, 32'h0, 0, 1);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    issue(32'h8000_0000, 32'h8000_0000, 0, 0);
    issue(32'h0001_0000, 32'h0001_0000, 0, 1);
    idle(3);
    // R2 signed corners
    issue(32'h8000_0000, 32'h8000_0000, 1, 1);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    issue(32'h8000_0000, 32'h7FFF_FFFF, 1, 1);
    issue(32'hFFFF_FFFF, 32'h0000_0001, 1, 0);
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1);
    issue(32'h0000_0000, 32'hFFFF_FFFF, 1, 1);
    idle(3);
    // R8 mode alternating every cycle, same operands
    for (int i = 0; i < 8; i++)
      issue(32'hF000_0003, 32'hC000_0005, i[0], i[1]);
    idle(3);

    // R7 reset with operations in flight
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1, 1);
    in_valid = 1'b1; op_a = 32'h5; op_b = 32'h7; set_cc = 1;
    #1 rst_n = 1'b0;
    exp_q.delete();
    in_valid = 1'b0;
    idle(2);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R7 no output after reset", 64'(out_valid), 64'd0);
      @(negedge clk);
    end

    // R8/R4 dense mixed stream with bubbles
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      if (i % 7 == 0) b = 32'h0;
      if (i % 11 == 0) a = 32'h8000_0000;
      issue(a, b, 1'($urandom()), 1'($urandom()));
      if ($urandom() % 4 == 0) idle(1);
    end
    idle(5);
    if (exp_q.size() != 0) check("R4 results outstanding", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule